// File: doc/BRIEF.md
# Flash Lock Bit Access Gate

This block keeps the two lock bytes that protect a code memory and rules on every access request that a command front end presents to it. Each cycle the front end can offer one request (a code read, a code program, a fuse or signature program, a signature or fuse read, or a request to enable on-chip debug). The gate answers in the same cycle with exactly one of an allow or a deny strobe. The answer depends on the protection mode that it decodes from the two stored bytes.

The lock bytes live in registers that come out of reset in the erased state. A lock write can only clear bits, so protection can be tightened but never loosened by writing. The only way back to the unprotected state is a chip-erase command. The request interface is a single-cycle strobe with no back-pressure, because the gate never stalls: every request presented with `req_valid` high is answered combinationally in that cycle. The gate accepts a new request every cycle.

Top module: `flash_lock_gate`

## Requirements
- R1: After reset both lock bytes read FFh and `prot_mode` is 1.
- R2: A lock byte counts as programmed when its value differs from FFh. `prot_mode` is 2 when the byte at lock address 00h is programmed and the byte at 01h is erased, and 3 when both are programmed. It is 1 in every other case, including when only the byte at 01h is programmed.
- R3: A lock write with `lock_wr_sel`=0 targets address 00h and with `lock_wr_sel`=1 targets address 01h. It stores the bitwise AND of the old value and `lock_wr_data`, so a write can never turn a 0 bit back into 1.
- R4: A cycle with `chip_erase` high returns both bytes to FFh and `prot_mode` to 1 on the next clock edge. This takes priority over a lock write in the same cycle.
- R5: While `req_valid` is high exactly one of `req_allow` and `req_deny` is high. While `req_valid` is low both are low.
- R6: Program requests (code program = 1, fuse program = 2, signature program = 6) are allowed only in mode 1.
- R7: A code read (type 0) is allowed in modes 1 and 2 and denied in mode 3.
- R8: Signature reads (type 3) and fuse reads (type 4) are allowed in every mode.
- R9: A debug enable (type 5) is allowed in modes 1 and 2 and denied in mode 3.
- R10: Request type 7 is reserved and always denied.
- R11: `lock_bytes` shows the byte at address 01h in bits 15:8 and the byte at 00h in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_wr_en | input | 1 | Lock write strobe |
| lock_wr_sel | input | 1 | Lock address: 0 for 00h, 1 for 01h |
| lock_wr_data | input | 8 | Value ANDed into the selected lock byte |
| chip_erase | input | 1 | Chip-erase command, restores both lock bytes |
| req_valid | input | 1 | Access request present this cycle |
| req_type | input | 3 | Request kind, encoded as in R6 to R10 |
| req_allow | output | 1 | Request permitted |
| req_deny | output | 1 | Request refused |
| prot_mode | output | 2 | Decoded protection mode, 1 to 3 |
| lock_bytes | output | 16 | Stored lock bytes {addr 01h, addr 00h} |

## Verification
The bench walks all four erased/programmed combinations of the two bytes and offers every request type, both with and without `req_valid`, in each of them. A decoder that keyed mode 2 on the wrong byte would report mode 2 when only address 01h is programmed, and it would be caught there. Partial writes (0Fh, then F0h) check that the bytes accumulate by AND. A write of FFh over a programmed byte checks that protection cannot be undone, where a plain overwrite would reopen the part. A chip erase issued together with a lock write checks erase priority, where a write winning would leave a byte programmed after the erase.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;
  typedef enum logic [1:0] {
    MODE_OPEN   = 2'd1,
    MODE_NOPROG = 2'd2,
    MODE_SEALED = 2'd3
  } prot_mode_e;

  typedef enum logic [2:0] {
    RQ_CODE_RD = 3'd0,
    RQ_CODE_PG = 3'd1,
    RQ_FUSE_PG = 3'd2,
    RQ_SIG_RD  = 3'd3,
    RQ_FUSE_RD = 3'd4,
    RQ_DBG_EN  = 3'd5,
    RQ_SIG_PG  = 3'd6,
    RQ_RSVD    = 3'd7
  } req_kind_e;
endpackage

// File: rtl/lock_byte_store.sv
module lock_byte_store #(
  parameter int NUM_LOCK = 2,
  parameter int BYTE_W   = 8,
  localparam int SEL_W   = (NUM_LOCK > 1) ? $clog2(NUM_LOCK) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           wr_sel,
  input  logic [BYTE_W-1:0]          wr_data,
  input  logic                       erase,
  output logic [NUM_LOCK*BYTE_W-1:0] bytes_q
);
  for (genvar g = 0; g < NUM_LOCK; g++) begin : g_byte
    logic [BYTE_W-1:0] val_q;
    logic              hit;
    assign hit = wr_en && (wr_sel == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     val_q <= '1;
      else if (erase) val_q <= '1;
      else if (hit)   val_q <= val_q & wr_data;
    end
    assign bytes_q[g*BYTE_W +: BYTE_W] = val_q;
  end
endmodule

// File: rtl/lock_mode_decode.sv
module lock_mode_decode
  import flash_lock_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] lock_lo,
  input  logic [BYTE_W-1:0] lock_hi,
  output prot_mode_e        mode
);
  logic lo_set, hi_set;
  assign lo_set = (lock_lo != '1);
  assign hi_set = (lock_hi != '1);

  always_comb begin
    if (!lo_set)     mode = MODE_OPEN;
    else if (hi_set) mode = MODE_SEALED;
    else             mode = MODE_NOPROG;
  end
endmodule

// File: rtl/access_policy.sv
module access_policy
  import flash_lock_pkg::*;
(
  input  prot_mode_e mode,
  input  logic       req_valid,
  input  req_kind_e  req_kind,
  output logic       allow,
  output logic       deny
);
  logic ok;
  always_comb begin
    unique case (req_kind)
      RQ_CODE_PG, RQ_FUSE_PG, RQ_SIG_PG: ok = (mode == MODE_OPEN);
      RQ_CODE_RD, RQ_DBG_EN:             ok = (mode != MODE_SEALED);
      RQ_SIG_RD, RQ_FUSE_RD:             ok = 1'b1;
      default:                           ok = 1'b0;
    endcase
  end
  assign allow = req_valid & ok;
  assign deny  = req_valid & ~ok;
endmodule

// File: rtl/flash_lock_gate.sv
module flash_lock_gate
  import flash_lock_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_wr_en,
  input  logic              lock_wr_sel,
  input  logic [BYTE_W-1:0] lock_wr_data,
  input  logic              chip_erase,
  input  logic              req_valid,
  input  logic [2:0]        req_type,
  output logic              req_allow,
  output logic              req_deny,
  output logic [1:0]        prot_mode,
  output logic [2*BYTE_W-1:0] lock_bytes
);
  localparam int NUM_LOCK = 2;

  prot_mode_e mode;

  lock_byte_store #(.NUM_LOCK(NUM_LOCK), .BYTE_W(BYTE_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (lock_wr_en),
    .wr_sel  (lock_wr_sel),
    .wr_data (lock_wr_data),
    .erase   (chip_erase),
    .bytes_q (lock_bytes)
  );

  lock_mode_decode #(.BYTE_W(BYTE_W)) u_decode (
    .lock_lo (lock_bytes[BYTE_W-1:0]),
    .lock_hi (lock_bytes[2*BYTE_W-1:BYTE_W]),
    .mode    (mode)
  );

  access_policy u_policy (
    .mode      (mode),
    .req_valid (req_valid),
    .req_kind  (req_kind_e'(req_type)),
    .allow     (req_allow),
    .deny      (req_deny)
  );

  assign prot_mode = mode;
endmodule

// File: rtl/flash_lock_gate_chk.sv
module flash_lock_gate_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_erase,
  input logic              req_valid,
  input logic [2:0]        req_type,
  input logic              req_allow,
  input logic              req_deny,
  input logic [1:0]        prot_mode,
  input logic [2*BYTE_W-1:0] lock_bytes
);
  logic is_prog;
  assign is_prog = (req_type == 3'd1) || (req_type == 3'd2) || (req_type == 3'd6);

  // R3: no bit of a lock byte rises unless an erase preceded
  a_r3_bits_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(chip_erase)) |-> ((lock_bytes & ~$past(lock_bytes)) == '0));

  a_r4_erase_restores: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase |=> (lock_bytes == '1 && prot_mode == 2'd1));

  a_r5_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot({req_allow, req_deny}));

  a_r5_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!req_allow && !req_deny));

  a_r6_no_prog_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_prog && prot_mode != 2'd1) |-> req_deny);

  a_r7_code_read_sealed: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type == 3'd0 && prot_mode == 2'd3) |-> req_deny);

  a_r8_info_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_type == 3'd3 || req_type == 3'd4)) |-> req_allow);

  a_r9_debug_sealed: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type == 3'd5 && prot_mode == 2'd3) |-> req_deny);

  a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type == 3'd7) |-> req_deny);
endmodule

bind flash_lock_gate flash_lock_gate_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/flash_lock_gate_bench.sv
module flash_lock_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lock_wr_en = 1'b0;
  logic        lock_wr_sel = 1'b0;
  logic [7:0]  lock_wr_data = 8'hFF;
  logic        chip_erase = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_type = 3'd0;
  logic        req_allow, req_deny;
  logic [1:0]  prot_mode;
  logic [15:0] lock_bytes;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] rb0 = 8'hFF, rb1 = 8'hFF;

  flash_lock_gate u_flash_lock_gate (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [1:0] ref_mode(logic [7:0] b0, logic [7:0] b1);
    if (b0 == 8'hFF) return 2'd1;
    if (b1 == 8'hFF) return 2'd2;
    return 2'd3;
  endfunction

  function automatic bit ref_ok(logic [1:0] m, logic [2:0] t);
    case (t)
      3'd1, 3'd2, 3'd6: return m == 2'd1;
      3'd0, 3'd5:       return m != 2'd3;
      3'd3, 3'd4:       return 1'b1;
      default:          return 1'b0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_state(string tag);
    check({tag, " lock_bytes R11"}, 32'(lock_bytes), 32'({rb1, rb0}));
    check({tag, " mode R2"}, 32'(prot_mode), 32'(ref_mode(rb0, rb1)));
  endtask

  task automatic wr(logic sel, logic [7:0] d, logic er);
    lock_wr_en = 1'b1; lock_wr_sel = sel; lock_wr_data = d; chip_erase = er;
    @(negedge clk);
    lock_wr_en = 1'b0; chip_erase = 1'b0; lock_wr_data = 8'hFF;
    if (er) begin rb0 = 8'hFF; rb1 = 8'hFF; end
    else if (sel) rb1 = rb1 & d;
    else          rb0 = rb0 & d;
  endtask

  task automatic erase();
    chip_erase = 1'b1;
    @(negedge clk);
    chip_erase = 1'b0;
    rb0 = 8'hFF; rb1 = 8'hFF;
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset bytes", 32'(lock_bytes), 32'h0000FFFF);
    check("R1 reset mode", 32'(prot_mode), 32'd1);

    // R2 R5 R6 R7 R8 R9 R10: all byte combinations x all request kinds
    for (int s = 0; s < 4; s++) begin
      erase();
      if (s[0]) wr(1'b0, 8'h00, 1'b0);
      if (s[1]) wr(1'b1, 8'h00, 1'b0);
      check_state("sweep");
      for (int t = 0; t < 8; t++) begin
        for (int v = 0; v < 2; v++) begin
          req_valid = v[0]; req_type = 3'(t);
          #1;
          check($sformatf("R5-R10 allow s=%0d t=%0d v=%0d", s, t, v),
                32'(req_allow), 32'(v[0] & ref_ok(ref_mode(rb0, rb1), 3'(t))));
          check($sformatf("R5 deny s=%0d t=%0d v=%0d", s, t, v),
                32'(req_deny), 32'(v[0] & ~ref_ok(ref_mode(rb0, rb1), 3'(t))));
        end
      end
      req_valid = 1'b0;
      @(negedge clk);
    end

    // R3 partial writes accumulate by AND
    erase();
    wr(1'b0, 8'h0F, 1'b0);
    check_state("R3 partial 0F");
    check("R3 byte0 0F", 32'(lock_bytes[7:0]), 32'h0F);
    wr(1'b0, 8'hF0, 1'b0);
    check("R3 byte0 and", 32'(lock_bytes[7:0]), 32'h00);
    // R3 writing FFh cannot undo programming
    wr(1'b0, 8'hFF, 1'b0);
    check("R3 no restore", 32'(lock_bytes[7:0]), 32'h00);
    check("R3 mode stays 2", 32'(prot_mode), 32'd2);
    wr(1'b1, 8'h5A, 1'b0);
    check_state("R3 byte1 partial");
    check("R3 mode 3 partial", 32'(prot_mode), 32'd3);
    wr(1'b1, 8'hFF, 1'b0);
    check("R3 byte1 keeps", 32'(lock_bytes[15:8]), 32'h5A);

    // R4 erase beats a same-cycle write
    wr(1'b0, 8'h00, 1'b1);
    check("R4 erase priority bytes", 32'(lock_bytes), 32'h0000FFFF);
    check("R4 erase mode", 32'(prot_mode), 32'd1);

    // R2 byte 01h alone keeps mode 1
    wr(1'b1, 8'h00, 1'b0);
    check("R2 hi only mode", 32'(prot_mode), 32'd1);
    req_valid = 1'b1; req_type = 3'd1; #1;
    check("R6 hi only program allowed", 32'(req_allow), 32'd1);
    req_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule